// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block sits behind the write port of a parallel NOR-flash style command interface and handles the erase side of it. A bus write is one address word, one data byte and a one-cycle strobe that marks the rising edge of the write enable. From these writes it decodes a chip-wide erase sequence and a sector erase sequence. After a sector erase sequence it keeps a collection window open, and during that window extra sectors can be added with single writes. When the window runs out, the selected sectors are erased one after another. Each sector is held for a fixed number of clock cycles and is announced to a simple array model by a one-hot request.

A sector erase can be paused and restarted. A pause takes effect at once if it arrives while the window is open. If it arrives during the erase itself, it takes effect after a fixed latency. A status read port mimics the flash status byte, so software can tell whether the block is erasing or paused, and whether the collection timer has run out. All window, latency and per-sector durations are parameters counted in clock cycles, so a bench can use short values. The active-low reset acts as the hardware reset and abandons any operation.

Top module: `fes_erase_seq`

## Requirements
- R1: After reset, busy, suspended, tmr_expired and erase_req are all 0.
- R2: The writes (addr[11:0], data) 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, then data 30h at any address open the collection window for the sector in wr_addr[15:13]: busy=1, tmr_expired=0. Any write that does not match its step sends the decoder back to read mode, and no window opens.
- R3: In the window, a write of 30h selects the sector in wr_addr[15:13] and restarts the window timer. The window closes, and tmr_expired rises, WIN_CYC cycles (one more for the first sector) after the last selecting write.
- R4: Any write in the window other than 30h or B0h drops the selection and returns to read mode: busy=0, and no sector is erased.
- R5: Selected sectors are erased one at a time, lowest index first. erase_req is one-hot on the current sector. erase_done pulses that sector's bit ERASE_CYC cycles after its erase starts, and busy falls after the last sector.
- R6: The chip sequence matches R2 but ends with 10h at 555h. It erases all NUM_SECT sectors with no window, and every write during it (B0h included) is ignored.
- R7: During a sector erase, writes other than B0h are ignored.
- R8: B0h written in the window suspends immediately. B0h written during a sector erase suspends SUSP_LAT cycles later. While suspended, erase_req is 0 and no sector completes.
- R9: A read (rd_stb) returns status (rd_is_status=1) while busy at any address, or while suspended at a selected sector. Reads of other sectors while suspended return rd_is_status=0. In the status byte, bit7=0 and bit3=tmr_expired. Bit6 toggles on each status read while busy and stays stable while suspended. Bit2 toggles on each status read of a selected sector.
- R10: While suspended, 30h at a sector still pending resumes the erase. 30h at another sector is ignored. Progress made before the suspend is kept. A repeated 30h after resuming is ignored, and a later B0h suspends again.
- R11: Asserting rst_n low in the middle of any operation returns to read mode at once, and the interrupted sectors never complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address; top SECT_W bits select the sector |
| wr_data | input | 8 | Write data byte (command code) |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_is_status | output | 1 | Last read returned status rather than array data |
| rd_dq | output | 8 | Status byte of the last read |
| busy | output | 1 | Window open or sector erase running |
| suspended | output | 1 | Erase suspended |
| tmr_expired | output | 1 | Collection window has closed and erase is underway or paused |
| erase_req | output | NUM_SECT | One-hot erase request to the array model |
| erase_done | output | NUM_SECT | One-cycle pulse: sector finished erasing |

## Verification
The assertions assume that writes and reads are single-cycle strobes separated by at least one idle cycle. They also assume that reset is held low for at least one clock edge. The bench drives every access through tasks that raise the strobe for one cycle and then idle for one cycle, and it asserts reset for two full cycles. The interval rules that the window and suspend timing depend on therefore always hold.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIN,
    ST_ERASE,
    ST_SPEND,
    ST_SUSP
  } fes_state_e;

  localparam int CMD_AW = 12;
  localparam logic [CMD_AW-1:0] ADR_A = 12'h555;
  localparam logic [CMD_AW-1:0] ADR_B = 12'h2AA;

  localparam logic [7:0] CMD_UNLK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLK2 = 8'h55;
  localparam logic [7:0] CMD_SETUP = 8'h80;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;
endpackage

// File: rtl/fes_cmd_decode.sv
module fes_cmd_decode
  import fes_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              sect_go,
  output logic              chip_go,
  output logic [SECT_W-1:0] go_sect
);
  localparam logic [2:0] LAST_STEP = 3'd5;

  logic [2:0]        step_q;
  logic [CMD_AW-1:0] exp_adr;
  logic [7:0]        exp_dat;
  logic              step_ok;
  logic              is_sect;
  logic              is_chip;
  logic [CMD_AW-1:0] cadr;

  assign cadr = wr_addr[CMD_AW-1:0];

  // expected cycle for each unlock/setup step
  always_comb begin
    exp_adr = ADR_A;
    exp_dat = CMD_UNLK1;
    unique case (step_q)
      3'd1:    begin exp_adr = ADR_B; exp_dat = CMD_UNLK2; end
      3'd2:    begin exp_adr = ADR_A; exp_dat = CMD_SETUP; end
      3'd3:    begin exp_adr = ADR_A; exp_dat = CMD_UNLK1; end
      3'd4:    begin exp_adr = ADR_B; exp_dat = CMD_UNLK2; end
      default: begin exp_adr = ADR_A; exp_dat = CMD_UNLK1; end
    endcase
  end

  assign step_ok = (cadr == exp_adr) && (wr_data == exp_dat);
  assign is_sect = (wr_data == CMD_SECT);
  assign is_chip = (wr_data == CMD_CHIP) && (cadr == ADR_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= '0;
      sect_go <= 1'b0;
      chip_go <= 1'b0;
      go_sect <= '0;
    end else begin
      sect_go <= 1'b0;
      chip_go <= 1'b0;
      if (!en) begin
        step_q <= '0;
      end else if (wr_stb) begin
        if (step_q != LAST_STEP) begin
          step_q <= step_ok ? step_q + 3'd1 : 3'd0;
        end else begin
          step_q  <= '0;
          sect_go <= is_sect;
          chip_go <= is_chip;
          go_sect <= wr_addr[ADDR_W-1 -: SECT_W];
        end
      end
    end
  end
endmodule

// File: rtl/fes_tick.sv
module fes_tick #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  input  logic         run,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= val;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/fes_rdstat.sv
module fes_rdstat #(
  parameter int NUM_SECT = 8,
  parameter int SECT_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_stb,
  input  logic [SECT_W-1:0]   rd_sect,
  input  logic                busy,
  input  logic                susp,
  input  logic                tmr,
  input  logic [NUM_SECT-1:0] sel,
  output logic                rd_is_status,
  output logic [7:0]          rd_dq
);
  logic t6_q, t2_q;
  logic sel_hit, give_stat, t6_n, t2_n;

  assign sel_hit   = sel[rd_sect];
  assign give_stat = busy || (susp && sel_hit);
  assign t6_n      = (give_stat && busy) ? ~t6_q : t6_q;
  assign t2_n      = (give_stat && sel_hit) ? ~t2_q : t2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t6_q         <= 1'b0;
      t2_q         <= 1'b0;
      rd_is_status <= 1'b0;
      rd_dq        <= '0;
    end else if (rd_stb) begin
      t6_q         <= t6_n;
      t2_q         <= t2_n;
      rd_is_status <= give_stat;
      rd_dq        <= give_stat ? {1'b0, t6_n, 2'b00, tmr, t2_n, 2'b00} : 8'h00;
    end
  end
endmodule

// File: rtl/fes_erase_seq.sv
module fes_erase_seq
  import fes_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_SECT  = 8,
  parameter int WIN_CYC   = 64,
  parameter int SUSP_LAT  = 16,
  parameter int ERASE_CYC = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                rd_stb,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic                rd_is_status,
  output logic [7:0]          rd_dq,
  output logic                busy,
  output logic                suspended,
  output logic                tmr_expired,
  output logic [NUM_SECT-1:0] erase_req,
  output logic [NUM_SECT-1:0] erase_done
);
  localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
  localparam int WIN_W  = $clog2(WIN_CYC + 1);
  localparam int LAT_W  = $clog2(SUSP_LAT + 1);
  localparam int ERS_W  = $clog2(ERASE_CYC + 1);

  fes_state_e          st_q, st_d;
  logic [NUM_SECT-1:0] sel_q, sel_d, rem_q, rem_d, done_q, done_d, cur_oh;
  logic                chip_q, chip_d;
  logic                win_ld, ers_ld, lat_ld;
  logic                win_zero, ers_zero, lat_zero;
  logic                sect_go, chip_go;
  logic [SECT_W-1:0]   go_sect, wr_sect, rd_sect;
  logic                in_erase;

  assign wr_sect  = wr_addr[ADDR_W-1 -: SECT_W];
  assign rd_sect  = rd_addr[ADDR_W-1 -: SECT_W];
  assign in_erase = (st_q == ST_ERASE) || (st_q == ST_SPEND);
  assign cur_oh   = rem_q & (~rem_q + NUM_SECT'(1));

  fes_cmd_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .en(st_q == ST_IDLE),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .sect_go(sect_go), .chip_go(chip_go), .go_sect(go_sect)
  );

  fes_tick #(.W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .load(win_ld), .val(WIN_W'(WIN_CYC - 1)),
    .run(st_q == ST_WIN), .zero(win_zero)
  );

  fes_tick #(.W(LAT_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .load(lat_ld), .val(LAT_W'(SUSP_LAT - 1)),
    .run(st_q == ST_SPEND), .zero(lat_zero)
  );

  fes_tick #(.W(ERS_W)) u_ers (
    .clk(clk), .rst_n(rst_n), .load(ers_ld), .val(ERS_W'(ERASE_CYC - 1)),
    .run(in_erase), .zero(ers_zero)
  );

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    rem_d  = rem_q;
    chip_d = chip_q;
    done_d = '0;
    win_ld = 1'b0;
    ers_ld = 1'b0;
    lat_ld = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (chip_go) begin
          sel_d  = '1;
          rem_d  = '1;
          chip_d = 1'b1;
          st_d   = ST_ERASE;
          ers_ld = 1'b1;
        end else if (sect_go) begin
          sel_d  = NUM_SECT'(1) << go_sect;
          rem_d  = NUM_SECT'(1) << go_sect;
          st_d   = ST_WIN;
          win_ld = 1'b1;
        end
      end
      ST_WIN: begin
        if (wr_stb) begin
          if (wr_data == CMD_SECT) begin
            sel_d  = sel_q | (NUM_SECT'(1) << wr_sect);
            rem_d  = rem_q | (NUM_SECT'(1) << wr_sect);
            win_ld = 1'b1;
          end else if (wr_data == CMD_SUSP) begin
            st_d   = ST_SUSP;
            ers_ld = 1'b1;
          end else begin
            st_d  = ST_IDLE;
            sel_d = '0;
            rem_d = '0;
          end
        end else if (win_zero) begin
          st_d   = ST_ERASE;
          ers_ld = 1'b1;
        end
      end
      ST_ERASE, ST_SPEND: begin
        if (ers_zero) begin
          done_d = cur_oh;
          rem_d  = rem_q & ~cur_oh;
          if ((rem_q & ~cur_oh) == '0) begin
            st_d   = ST_IDLE;
            sel_d  = '0;
            chip_d = 1'b0;
          end else begin
            ers_ld = 1'b1;
          end
        end
        if (st_d != ST_IDLE) begin
          if ((st_q == ST_ERASE) && wr_stb && (wr_data == CMD_SUSP) && !chip_q) begin
            st_d   = ST_SPEND;
            lat_ld = 1'b1;
          end else if ((st_q == ST_SPEND) && lat_zero) begin
            st_d = ST_SUSP;
          end
        end
      end
      ST_SUSP: begin
        if (wr_stb && (wr_data == CMD_SECT) && rem_q[wr_sect]) begin
          st_d = ST_ERASE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sel_q  <= '0;
      rem_q  <= '0;
      chip_q <= 1'b0;
      done_q <= '0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      rem_q  <= rem_d;
      chip_q <= chip_d;
      done_q <= done_d;
    end
  end

  assign busy        = (st_q == ST_WIN) || in_erase;
  assign suspended   = (st_q == ST_SUSP);
  assign tmr_expired = in_erase || suspended;
  assign erase_req   = in_erase ? cur_oh : '0;
  assign erase_done  = done_q;

  fes_rdstat #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_sect(rd_sect),
    .busy(busy), .susp(suspended), .tmr(tmr_expired), .sel(sel_q),
    .rd_is_status(rd_is_status), .rd_dq(rd_dq)
  );
endmodule

// File: rtl/fes_erase_seq_chk.sv
module fes_erase_seq_chk #(
  parameter int NUM_SECT = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                suspended,
  input logic                rd_is_status,
  input logic [NUM_SECT-1:0] erase_req,
  input logic [NUM_SECT-1:0] erase_done
);
  // R5
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(erase_req));

  // R5
  done_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_done != '0) |-> (erase_done == $past(erase_req)));

  // R8
  susp_idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (erase_req == '0));

  // R8
  susp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> $past(busy));

  // R9
  status_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_is_status) |-> $past(busy || suspended));

  // R11
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !suspended && (erase_req == '0)));
endmodule

bind fes_erase_seq fes_erase_seq_chk #(.NUM_SECT(NUM_SECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .suspended(suspended),
  .rd_is_status(rd_is_status), .erase_req(erase_req), .erase_done(erase_done)
);

// File: tb/fes_erase_seq_test.sv
module fes_erase_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NS = 8;
  localparam int WIN = 40;
  localparam int LAT = 6;
  localparam int ERS = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rd_stb = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_is_status;
  logic [7:0] rd_dq;
  logic busy, suspended, tmr_expired;
  logic [NS-1:0] erase_req, erase_done;

  int n_chk = 0;
  int n_fail = 0;
  int done_cnt = 0;
  logic [NS-1:0] done_log [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  fes_erase_seq #(.ADDR_W(AW), .NUM_SECT(NS), .WIN_CYC(WIN), .SUSP_LAT(LAT),
                  .ERASE_CYC(ERS)) uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_is_status(rd_is_status), .rd_dq(rd_dq),
    .busy(busy), .suspended(suspended), .tmr_expired(tmr_expired),
    .erase_req(erase_req), .erase_done(erase_done)
  );

  always @(negedge clk) begin
    if (erase_done != '0) begin
      if (done_cnt < 16) done_log[done_cnt] = erase_done;
      done_cnt++;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] sa(input int s);
    return {s[2:0], 13'h0123};
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic st, output logic [7:0] dq);
    @(negedge clk);
    rd_addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    st = rd_is_status; dq = rd_dq;
  endtask

  task automatic prefix();
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55);
  endtask

  task automatic sect_seq(input int s);
    prefix(); wr(sa(s), 8'h30);
  endtask

  task automatic chip_seq();
    prefix(); wr(16'h0555, 8'h10);
  endtask

  task automatic wait_tmr(output int n);
    n = 0;
    while (!tmr_expired && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (erase_done == '0 && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_susp(output int n);
    n = 0;
    while (!suspended && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((busy || suspended) && n < 5000) begin @(negedge clk); n++; end
    cyc(2);
  endtask

  task automatic t_reset();
    chk(!busy && !suspended && !tmr_expired && erase_req == '0, "R1 reset state",
        {busy, suspended, tmr_expired, erase_req}, 0);
  endtask

  task automatic t_single();
    int n;
    done_cnt = 0;
    sect_seq(3);
    chk(busy && !tmr_expired, "R2 window open", {busy, tmr_expired}, 2'b10);
    wait_tmr(n);
    chk(n >= WIN - 1 && n <= WIN, "R3 window length", n, WIN);
    chk(erase_req == 8'h08, "R5 erase_req one-hot", erase_req, 8'h08);
    wait_done(n);
    chk(n == ERS, "R5 per-sector erase time", n, ERS);
    wait_idle();
    chk(done_cnt == 1 && done_log[0] == 8'h08 && !busy, "R5 single sector done",
        done_cnt, 1);
  endtask

  task automatic t_mismatch();
    done_cnt = 0;
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h56); wr(sa(2), 8'h30);
    cyc(3);
    chk(!busy && !tmr_expired, "R2 mismatched cycle aborts", busy, 0);
  endtask

  task automatic t_multi();
    int n;
    done_cnt = 0;
    sect_seq(5);
    cyc(10);
    wr(sa(1), 8'h30);
    cyc(10);
    wr(sa(6), 8'h30);
    wait_tmr(n);
    chk(n >= WIN - 1 && n <= WIN, "R3 window restarted by added sector", n, WIN);
    wait_idle();
    chk(done_cnt == 3, "R5 three sectors erased", done_cnt, 3);
    chk(done_log[0] == 8'h02 && done_log[1] == 8'h20 && done_log[2] == 8'h40,
        "R5 lowest index first", {done_log[0], done_log[1], done_log[2]}, 24'h022040);
  endtask

  task automatic t_abort();
    done_cnt = 0;
    sect_seq(2);
    wr(16'h0555, 8'hAA);
    cyc(1);
    chk(!busy && !tmr_expired, "R4 foreign command aborts", busy, 0);
    cyc(WIN + ERS + 10);
    chk(done_cnt == 0, "R4 no sector erased after abort", done_cnt, 0);
  endtask

  task automatic t_chip();
    done_cnt = 0;
    chip_seq();
    cyc(1);
    chk(busy && tmr_expired, "R6 chip erase starts without window",
        {busy, tmr_expired}, 2'b11);
    wr(sa(3), 8'hB0);
    wr(16'h0555, 8'hAA);
    cyc(LAT + 5);
    chk(busy && !suspended, "R6 suspend ignored in chip erase", suspended, 0);
    wait_idle();
    chk(done_cnt == NS, "R6 all sectors erased", done_cnt, NS);
    begin
      bit ord = 1'b1;
      for (int i = 0; i < NS; i++) if (done_log[i] != (8'h01 << i)) ord = 1'b0;
      chk(ord, "R6 chip erase order", ord, 1);
    end
  endtask

  task automatic t_ignore();
    int n;
    done_cnt = 0;
    sect_seq(4);
    wait_tmr(n);
    wr(sa(0), 8'hF0);
    wr(16'h0555, 8'hAA);
    chk(busy && tmr_expired && erase_req == 8'h10, "R7 command ignored in erase",
        erase_req, 8'h10);
    wait_idle();
    chk(done_cnt == 1 && done_log[0] == 8'h10, "R7 erase completed", done_cnt, 1);
  endtask

  task automatic t_susp_win();
    logic st; logic [7:0] dq;
    done_cnt = 0;
    sect_seq(0);
    wr(sa(7), 8'h30);
    wr(sa(7), 8'hB0);
    chk(suspended && !busy && erase_req == '0, "R8 window suspend immediate",
        {suspended, busy}, 2'b10);
    rd(sa(7), st, dq);
    chk(st == 1'b1, "R9 suspended selected sector gives status", st, 1);
    rd(sa(3), st, dq);
    chk(st == 1'b0, "R9 unselected sector readable", st, 0);
    wr(sa(3), 8'h30);
    chk(suspended, "R10 resume at unselected sector ignored", suspended, 1);
    cyc(ERS);
    chk(done_cnt == 0, "R8 nothing completes while suspended", done_cnt, 0);
    wr(sa(7), 8'h30);
    chk(busy && !suspended, "R10 resume", {busy, suspended}, 2'b10);
    wait_idle();
    chk(done_cnt == 2 && done_log[0] == 8'h01 && done_log[1] == 8'h80,
        "R10 resumed sectors erased", done_cnt, 2);
  endtask

  task automatic t_susp_erase();
    int n;
    logic s1, s2; logic [7:0] d1, d2;
    done_cnt = 0;
    sect_seq(6);
    wait_tmr(n);
    rd(sa(6), s1, d1);
    rd(sa(6), s2, d2);
    chk(s1 && s2 && !d1[7] && d1[3], "R9 busy status bits", d1, 8'h08);
    chk(d1[6] != d2[6] && d1[2] != d2[2], "R9 bit6/bit2 toggle while erasing",
        {d1[6], d2[6], d1[2], d2[2]}, 4'b1010);
    cyc(3);
    wr(sa(6), 8'hB0);
    wait_susp(n);
    chk(n >= LAT - 1 && n <= LAT, "R8 suspend latency", n, LAT);
    chk(erase_req == '0, "R8 no request while suspended", erase_req, 0);
    cyc(ERS);
    chk(done_cnt == 0, "R8 progress held", done_cnt, 0);
    rd(sa(6), s1, d1);
    rd(sa(6), s2, d2);
    chk(s1 && s2 && d1[6] == d2[6] && d1[2] != d2[2], "R9 suspended status toggles",
        {d1[6], d2[6], d1[2], d2[2]}, 4'b0010);
    wr(sa(6), 8'h30);
    wr(sa(6), 8'h30);
    chk(busy && !suspended, "R10 repeated resume ignored", {busy, suspended}, 2'b10);
    wr(sa(6), 8'hB0);
    wait_susp(n);
    chk(suspended && done_cnt == 0, "R10 second suspend", suspended, 1);
    wr(sa(6), 8'h30);
    wait_done(n);
    chk(n < ERS - 10, "R10 remaining time preserved", n, ERS);
    wait_idle();
    chk(done_cnt == 1 && done_log[0] == 8'h40, "R10 sector completed", done_cnt, 1);
  endtask

  task automatic t_hwreset();
    int n;
    done_cnt = 0;
    sect_seq(1);
    wait_tmr(n);
    @(negedge clk); rst_n = 1'b0;
    cyc(2);
    chk(!busy && !suspended && !tmr_expired && erase_req == '0,
        "R11 reset aborts erase", {busy, suspended, tmr_expired}, 0);
    rst_n = 1'b1;
    cyc(ERS + 10);
    chk(done_cnt == 0 && !busy, "R11 aborted sector never completes", done_cnt, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_single();
    t_mismatch();
    t_multi();
    t_abort();
    t_chip();
    t_ignore();
    t_susp_win();
    t_susp_erase();
    t_hwreset();
    finish_run();
  end
endmodule